// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block is the control-flow engine of an 8-bit processor with a 16-bit address space. After the opcode has been decoded elsewhere, the core pulses `start` with the branch kind, a condition selector, the Z and C flags, the program counter (pointing at the first byte after the opcode) and the stack pointer. The sequencer then walks the single byte-wide memory port one access per cycle. It fetches operand bytes, pushes or pops the return address, and works out whether the branch is taken. It returns the new program counter, the new stack pointer and the number of clock cycles the instruction is charged.

Four kinds are handled: an absolute jump with a 16-bit target, a relative jump with a signed 8-bit offset, a subroutine call and a subroutine return. Each kind can be unconditional or gated on a flag. An untaken branch still spends its operand fetches. A return address is always moved over the byte bus as the low byte first, then the high byte. The flags are captured when `start` is accepted.

States: `ST_IDLE` waits for `start`. From there it goes to `ST_PUSH_LO` for a taken call, to `ST_POP_LO` for a return, and to `ST_OPND_LO` otherwise. `ST_PUSH_LO` always moves to `ST_PUSH_HI`, and `ST_PUSH_HI` moves to `ST_OPND_LO`. `ST_OPND_LO` moves to `ST_FINISH` for a relative jump and to `ST_OPND_HI` otherwise. `ST_OPND_HI` moves to `ST_FINISH`. `ST_POP_LO` moves to `ST_POP_HI` when the return is taken and to `ST_FINISH` when it is not. `ST_POP_HI` moves to `ST_FINISH`. `ST_FINISH` publishes the results and returns to `ST_IDLE`.

Top module: `branch_seq`

## Requirements
- R1: Condition selector `cond_sel` encoding: 0 always, 1 carry set, 2 zero set, 3 carry clear, 4 zero clear, 5 to 7 always. The flags are sampled in the cycle `start` is accepted, and later flag changes have no effect.
- R2: Kind 0 (absolute jump) reads `pc_in`, then `pc_in+1`. When taken, `pc_out` = {second byte, first byte}. When not taken, `pc_out` = `pc_in+2`. `sp_out` = `sp_in` in both cases.
- R3: Kind 1 (relative jump) reads `pc_in` once. When taken, `pc_out` = `pc_in+1` plus the sign-extended byte, modulo 2^16. When not taken, `pc_out` = `pc_in+1`.
- R4: Kind 2 (call), taken: the block first writes (`pc_in+2`)[7:0] at `sp_in-2`, then (`pc_in+2`)[15:8] at `sp_in-1`, with all addresses modulo 2^16. It then reads `pc_in` and `pc_in+1`. `pc_out` = {high operand, low operand} and `sp_out` = `sp_in-2`.
- R5: Kind 2, not taken: the block reads `pc_in` and `pc_in+1` with no write. `pc_out` = `pc_in+2` and `sp_out` = `sp_in`.
- R6: Kind 3 (return), taken: the block reads `sp_in`, then `sp_in+1`. `pc_out` = {second byte, first byte} and `sp_out` = `sp_in+2` modulo 2^16.
- R7: Kind 3, not taken: the block makes exactly one read, at `sp_in`. `pc_out` = `pc_in` and `sp_out` = `sp_in`.
- R8: `cycles_out` = 4 × (1 + memory accesses), plus 4 when the branch is taken. This gives jump 12/16, relative 8/12, call 12/24 and return 8/16 (untaken/taken).
- R9: `busy` rises in the cycle after `start` is accepted and stays high through the sequence. `done` is a one-cycle pulse, asserted N+2 cycles after the accepting edge, where N is the number of accesses. `busy` falls in the same cycle. The outputs are valid from `done` on, and `start` is ignored while `busy`.
- R10: Each access takes one cycle. `mem_rd` and `mem_wr` are never asserted together, and neither is asserted while idle. The two push writes occur on consecutive cycles at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a branch sequence (accepted when idle) |
| kind | input | 2 | 0 jump, 1 relative jump, 2 call, 3 return |
| cond_sel | input | 3 | Condition selector (see R1) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Program counter, pointing past the opcode |
| sp_in | input | 16 | Stack pointer |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| cycles_out | output | 8 | Cycle count charged to the instruction |

## Verification
Each result has a fixed arrival time counted from the clock edge that accepts `start`. The first memory access appears one cycle later, and each further access follows one cycle after the one before. `done`, together with the final `pc_out`, `sp_out` and `cycles_out`, arrives exactly N+2 cycles after that edge, where N is the access count for the kind and outcome. The bench samples on falling edges and counts them from the start pulse. It logs each access in the cycle where its strobe is high, compares the completion cycle against N+2, and reads the results only in the `done` cycle.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

    typedef enum logic [1:0] {
        BK_JUMP = 2'd0,
        BK_REL  = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    localparam logic [2:0] SEL_ALWAYS = 3'd0;
    localparam logic [2:0] SEL_C      = 3'd1;
    localparam logic [2:0] SEL_Z      = 3'd2;
    localparam logic [2:0] SEL_NC     = 3'd3;
    localparam logic [2:0] SEL_NZ     = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_OPND_LO,
        ST_OPND_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/bseq_cond.sv
module bseq_cond
    import branch_seq_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       taken
);
    always_comb begin
        unique case (sel)
            SEL_C:   taken = flag_c;
            SEL_Z:   taken = flag_z;
            SEL_NC:  taken = !flag_c;
            SEL_NZ:  taken = !flag_z;
            default: taken = 1'b1;
        endcase
    end
endmodule

// File: rtl/bseq_target.sv
module bseq_target
    import branch_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  br_kind_e           kind,
    input  logic               taken,
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic [DATA_W-1:0]  byte_lo,
    input  logic [DATA_W-1:0]  byte_hi,
    output logic [ADDR_W-1:0]  pc_next
);
    logic [ADDR_W-1:0] rel_ext;
    assign rel_ext = {{DATA_W{byte_lo[DATA_W-1]}}, byte_lo};

    always_comb begin
        if (!taken) begin
            pc_next = pc_cur;
        end else if (kind == BK_REL) begin
            pc_next = pc_cur + rel_ext;
        end else begin
            pc_next = {byte_hi, byte_lo};
        end
    end
endmodule

// File: rtl/bseq_cycles.sv
module bseq_cycles #(
    parameter int CNT_W          = 8,
    parameter int ACC_W          = 3,
    parameter int CYC_PER_ACCESS = 4,
    parameter int TAKEN_EXTRA    = 4
) (
    input  logic [ACC_W-1:0] accesses,
    input  logic             taken,
    output logic [CNT_W-1:0] cycles
);
    logic [CNT_W-1:0] base;
    always_comb begin
        base   = CNT_W'(CYC_PER_ACCESS) * (CNT_W'(accesses) + CNT_W'(1));
        cycles = taken ? base + CNT_W'(TAKEN_EXTRA) : base;
    end
endmodule

// File: rtl/branch_seq.sv
module branch_seq
    import branch_seq_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int CNT_W          = 8,
    parameter int CYC_PER_ACCESS = 4,
    parameter int TAKEN_EXTRA    = 4,
    localparam int ADDR_W        = 2 * DATA_W,
    localparam int ACC_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        kind,
    input  logic [2:0]        cond_sel,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [CNT_W-1:0]  cycles_out
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    seq_state_e        state, nxt;
    br_kind_e          kind_q;
    logic              taken_q;
    logic              taken_now;
    logic [ADDR_W-1:0] pc_w, sp_w, ret_q, pc_next;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [ACC_W-1:0]  acc_q;
    logic [CNT_W-1:0]  cyc_calc;

    bseq_cond u_cond (
        .sel    (cond_sel),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .taken  (taken_now)
    );

    bseq_target #(.DATA_W(DATA_W)) u_target (
        .kind    (kind_q),
        .taken   (taken_q),
        .pc_cur  (pc_w),
        .byte_lo (lo_q),
        .byte_hi (hi_q),
        .pc_next (pc_next)
    );

    bseq_cycles #(
        .CNT_W          (CNT_W),
        .ACC_W          (ACC_W),
        .CYC_PER_ACCESS (CYC_PER_ACCESS),
        .TAKEN_EXTRA    (TAKEN_EXTRA)
    ) u_cycles (
        .accesses (acc_q),
        .taken    (taken_q),
        .cycles   (cyc_calc)
    );

    assign busy = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and memory port
    always_comb begin
        nxt       = state;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (br_kind_e'(kind))
                        BK_CALL: nxt = taken_now ? ST_PUSH_LO : ST_OPND_LO;
                        BK_RET:  nxt = ST_POP_LO;
                        default: nxt = ST_OPND_LO;
                    endcase
                end
            end
            ST_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_w;
                mem_wdata = ret_q[DATA_W-1:0];
                nxt       = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_w + ONE;
                mem_wdata = ret_q[ADDR_W-1:DATA_W];
                nxt       = ST_OPND_LO;
            end
            ST_OPND_LO: begin
                mem_rd   = 1'b1;
                mem_addr = pc_w;
                nxt      = (kind_q == BK_REL) ? ST_FINISH : ST_OPND_HI;
            end
            ST_OPND_HI: begin
                mem_rd   = 1'b1;
                mem_addr = pc_w;
                nxt      = ST_FINISH;
            end
            ST_POP_LO: begin
                mem_rd   = 1'b1;
                mem_addr = sp_w;
                nxt      = taken_q ? ST_POP_HI : ST_FINISH;
            end
            ST_POP_HI: begin
                mem_rd   = 1'b1;
                mem_addr = sp_w + ONE;
                nxt      = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= BK_JUMP;
            taken_q    <= 1'b0;
            pc_w       <= '0;
            sp_w       <= '0;
            ret_q      <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            acc_q      <= '0;
            pc_out     <= '0;
            sp_out     <= '0;
            cycles_out <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (mem_rd || mem_wr) acc_q <= acc_q + ACC_W'(1);
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        kind_q  <= br_kind_e'(kind);
                        taken_q <= taken_now;
                        pc_w    <= pc_in;
                        sp_w    <= (br_kind_e'(kind) == BK_CALL && taken_now) ? sp_in - TWO : sp_in;
                        ret_q   <= pc_in + TWO;
                        acc_q   <= '0;
                    end
                end
                ST_OPND_LO: begin
                    lo_q <= mem_rdata;
                    pc_w <= pc_w + ONE;
                end
                ST_OPND_HI: begin
                    hi_q <= mem_rdata;
                    pc_w <= pc_w + ONE;
                end
                ST_POP_LO: lo_q <= mem_rdata;
                ST_POP_HI: begin
                    hi_q <= mem_rdata;
                    sp_w <= sp_w + TWO;
                end
                ST_FINISH: begin
                    pc_out     <= pc_next;
                    sp_out     <= sp_w;
                    cycles_out <= cyc_calc;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);
    // R10: strobes are mutually exclusive
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10: no memory traffic while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R4: the high push byte follows the low one at the next address
    a_r4_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |=> (mem_wr && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy ends exactly when done appears
    a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: no completion while still busy
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind branch_seq branch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/branch_seq_tb.sv
`timescale 1ns/1ps
module branch_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = '0;
    logic [2:0]  cond_sel = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, busy, done;
    logic [15:0] pc_out, sp_out;
    logic [7:0]  cycles_out;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem [2048];

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[10:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[10:0]] <= mem_wdata;

    branch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .cond_sel(cond_sel),
        .flag_z(flag_z), .flag_c(flag_c), .pc_in(pc_in), .sp_in(sp_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
        .pc_out(pc_out), .sp_out(sp_out), .cycles_out(cycles_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit cond_ok(input logic [2:0] s, input logic z, input logic c);
        case (s)
            3'd1: return c;
            3'd2: return z;
            3'd3: return !c;
            3'd4: return !z;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] rd_mem(input logic [15:0] a);
        return mem[a[10:0]];
    endfunction

    task automatic run_op(input logic [1:0] k, input logic [2:0] s, input logic fz,
                          input logic fc, input logic [15:0] p, input logic [15:0] sp,
                          input bit poke);
        bit          tk;
        int          n = 0;
        bit          e_wr [8];
        logic [15:0] e_ad [8];
        logic [7:0]  e_da [8];
        bit          a_wr [8];
        logic [15:0] a_ad [8];
        logic [7:0]  a_da [8];
        int          na = 0;
        int          lat = 0;
        bit          trace_ok;
        string       rq;
        logic [15:0] x_pc, x_sp, ret;
        logic [7:0]  x_cy, lo, hi;
        tk  = cond_ok(s, fz, fc);
        ret = p + 16'd2;
        x_sp = sp;
        case (k)
            2'd0: begin
                rq = "R2";
                e_wr[0] = 0; e_ad[0] = p;
                e_wr[1] = 0; e_ad[1] = p + 16'd1; n = 2;
                lo = rd_mem(p); hi = rd_mem(p + 16'd1);
                x_pc = tk ? {hi, lo} : p + 16'd2;
            end
            2'd1: begin
                rq = "R3";
                e_wr[0] = 0; e_ad[0] = p; n = 1;
                lo = rd_mem(p);
                x_pc = tk ? p + 16'd1 + {{8{lo[7]}}, lo} : p + 16'd1;
            end
            2'd2: begin
                rq = tk ? "R4" : "R5";
                if (tk) begin
                    e_wr[0] = 1; e_ad[0] = sp - 16'd2; e_da[0] = ret[7:0];
                    e_wr[1] = 1; e_ad[1] = sp - 16'd1; e_da[1] = ret[15:8];
                    n = 2; x_sp = sp - 16'd2;
                end
                e_wr[n] = 0; e_ad[n] = p; n++;
                e_wr[n] = 0; e_ad[n] = p + 16'd1; n++;
                lo = rd_mem(p); hi = rd_mem(p + 16'd1);
                x_pc = tk ? {hi, lo} : p + 16'd2;
            end
            default: begin
                rq = tk ? "R6" : "R7";
                e_wr[0] = 0; e_ad[0] = sp; n = 1;
                if (tk) begin e_wr[1] = 0; e_ad[1] = sp + 16'd1; n = 2; end
                lo = rd_mem(sp); hi = rd_mem(sp + 16'd1);
                x_pc = tk ? {hi, lo} : p;
                x_sp = tk ? sp + 16'd2 : sp;
            end
        endcase
        x_cy = 8'(4 * (1 + n) + (tk ? 4 : 0));

        @(negedge clk);
        kind = k; cond_sel = s; flag_z = fz; flag_c = fc;
        pc_in = p; sp_in = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: flip flags after acceptance; result must not change
        flag_z = !fz; flag_c = !fc;
        forever begin
            lat++;
            if (lat == 1) check(busy == 1'b1, "R9", "busy after start", 32'(busy), 1);
            if (poke && lat == 1) begin
                start = 1'b1; kind = ~k; pc_in = ~p; sp_in = ~sp;
            end
            if (poke && lat == 2) start = 1'b0;
            if (mem_rd || mem_wr) begin
                if (na < 8) begin
                    a_wr[na] = mem_wr; a_ad[na] = mem_addr; a_da[na] = mem_wdata;
                end
                na++;
            end
            if (done) break;
            if (lat > 40) begin
                check(1'b0, "R9", "watchdog: no done", 32'(lat), 32'(n + 2));
                break;
            end
            @(negedge clk);
        end
        check(lat == n + 2, "R9", "done latency", 32'(lat), 32'(n + 2));
        check(!busy, "R9", "busy low at done", 32'(busy), 0);
        check(pc_out == x_pc, rq, "pc_out", 32'(pc_out), 32'(x_pc));
        check(sp_out == x_sp, rq, "sp_out", 32'(sp_out), 32'(x_sp));
        check(cycles_out == x_cy, "R8", "cycles_out", 32'(cycles_out), 32'(x_cy));
        check(na == n, "R10", "access count", 32'(na), 32'(n));
        trace_ok = (na == n);
        for (int i = 0; i < n && i < 8; i++) begin
            if (trace_ok && (a_wr[i] != e_wr[i] || a_ad[i] != e_ad[i] ||
                             (e_wr[i] && a_da[i] != e_da[i]))) begin
                trace_ok = 0;
                check(1'b0, rq, $sformatf("access %0d addr/data", i),
                      {a_ad[i], a_da[i], 7'd0, a_wr[i]}, {e_ad[i], e_da[i], 7'd0, e_wr[i]});
            end
        end
        if (trace_ok) check(1'b1, rq, "trace", 0, 0);
        @(negedge clk);
        check(!done, "R9", "done one cycle", 32'(done), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 2048; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R9", "reset idle",
              {28'd0, busy, done, mem_rd, mem_wr}, 0);
        check(pc_out == 16'd0 && sp_out == 16'd0 && cycles_out == 8'd0, "R9", "reset outputs",
              32'(pc_out), 0);

        // directed corner cases
        run_op(2'd0, 3'd0, 0, 0, 16'h1200, 16'hC510, 0);  // R2 always
        run_op(2'd0, 3'd1, 0, 0, 16'h1210, 16'hC510, 0);  // R1 carry set false
        run_op(2'd0, 3'd3, 0, 0, 16'h1220, 16'hC510, 0);  // R1 carry clear true
        run_op(2'd0, 3'd2, 1, 0, 16'h1230, 16'hC510, 0);  // R1 zero set true
        run_op(2'd0, 3'd4, 1, 0, 16'h1240, 16'hC510, 0);  // R1 zero clear false
        run_op(2'd0, 3'd6, 0, 0, 16'h1250, 16'hC510, 0);  // R1 reserved selector
        mem[11'h000] = 8'h80;
        run_op(2'd1, 3'd0, 0, 0, 16'h0000, 16'hC510, 0);  // R3 negative wrap
        mem[11'h3FE] = 8'h7F;
        run_op(2'd1, 3'd0, 0, 0, 16'hFBFE, 16'hC510, 0);  // R3 positive offset
        run_op(2'd2, 3'd0, 0, 0, 16'h0200, 16'h0001, 0);  // R4 stack wraps below zero
        run_op(2'd2, 3'd2, 0, 0, 16'h0210, 16'h0550, 0);  // R5 untaken call
        run_op(2'd3, 3'd0, 0, 0, 16'h0220, 16'hFFFF, 0);  // R6 pop across wrap
        run_op(2'd3, 3'd3, 0, 1, 16'h0230, 16'h0560, 0);  // R7 untaken return
        run_op(2'd2, 3'd0, 0, 0, 16'h0240, 16'h0570, 1);  // R9 start ignored while busy

        // constrained random
        for (int t = 0; t < 300; t++) begin
            logic [15:0] rp, rs;
            rp = {5'($urandom), 1'b0, 10'($urandom)};
            rs = {5'($urandom), 3'b101, 8'($urandom)};
            run_op(2'($urandom), 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                   rp, rs, ($urandom_range(0, 9) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL R9 global watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule